// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Control Register

This block is a watchdog timer for a small controller. Software configures it through an 8-bit control register on a simple special-function-register bus. The register holds a 3-bit period select, an enable bit and a restart bit. The period select doubles the timeout with each step, from 16 up to 2048 timebase ticks; with a 1 ms tick that spans 16 ms to 2048 ms. The restart bit is write-only and acts as a one-cycle pulse. When the register is read, the position of the restart bit returns the ready status of a nonvolatile memory instead. If software does not restart the counter in time, the block raises a one-cycle reset request, and the counter then begins a fresh period at once.

The register also stores three memory-control bits (bits 4 to 2), which are simply held and read back. A second register carries a power-off flag in bit 4. Only a power-on reset sets this flag. Ordinary reset leaves it as it is, and software may set or clear it.

The counter is driven by a three-state machine:
- **WD_OFF**: the watchdog is disabled. It moves to WD_RUN once enable is set.
- **WD_RUN**: the watchdog counts ticks. It moves to WD_BITE when the terminal count is hit, and back to WD_OFF when enable is cleared.
- **WD_BITE**: this is the single request cycle. It returns to WD_RUN, or to WD_OFF if enable has been cleared.

Top module: `prescaled_watchdog`

## Requirements
- R1: After ordinary reset, the control register at address 0x96 reads 0x02 while `nvm_busy` is 0. All stored fields are 0 and `wd_reset_req` is 0.
- R2: A write to 0x96 stores bits 7:5 (period select), bits 4:2 (memory-control bits) and bit 0 (enable). A read returns them at the same positions.
- R3: Bit 1 is never stored. A read of bit 1 returns 1 when `nvm_busy` is 0 (ready) and 0 when it is 1 (busy).
- R4: Writing 1 to bit 1 creates a one-cycle restart pulse in the cycle after the write. That pulse clears the counter. With a tick on every cycle, the next request comes 16·2^PS+1 clock edges after the write edge.
- R5: While enabled, the request rises in the cycle after the clock edge that accepts the 16·2^PS-th tick since enabling, and it stays high for exactly one cycle.
- R6: After a request the counter restarts at zero and keeps counting. The next request follows exactly 16·2^PS ticks after the previous one.
- R7: While bit 0 is 0, no request is raised and the counter is held at zero. Enabling again starts a full period.
- R8: Only clock edges with `tick_1ms` high advance the counter. The request comes after 16·2^PS accepted ticks, whatever the number of clock edges in between.
- R9: The power-off flag is bit 4 of the register at address 0x87. It is set by `por_n` low, can be written by software, and is unchanged by `rst_n`. Bits 7:5 and 3:0 of that register read 0.
- R10: Writes to other addresses change no register, and reads of other addresses return 0.
- R11: If the period select is lowered so that the count already reaches the new terminal value, the request fires after the next accepted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Ordinary asynchronous reset, active low |
| por_n | input | 1 | Power-on reset, active low; sets the power-off flag |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for `sfr_addr` (combinational) |
| tick_1ms | input | 1 | Timebase tick, one clock wide |
| nvm_busy | input | 1 | Nonvolatile memory busy status |
| wd_reset_req | output | 1 | One-cycle reset request on timeout |

## Verification
A wrong count or a wrong terminal tap shows up as a request that arrives too early or too late. This shows in the first period after enabling, and the bench measures that period exactly for every period-select value. A state machine stuck in WD_BITE, or a counter that is not cleared, shows as a request wider than one cycle, as a repeat period that is off, or as a request while disabled, all within one period. Register faults appear on the very next read: a stored restart bit, a lost field, or a power-off flag disturbed by reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int REG_W   = 8;
    localparam int F_EN    = 0;
    localparam int F_KICK  = 1;
    localparam int F_MEM_LO = 2;
    localparam int F_MEM_HI = 4;
    localparam int F_PS_LO = 5;
    localparam int F_POF   = 4;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_BITE = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_pkg::*;
#(
    parameter logic [7:0] CTRL_ADDR = 8'h96,
    parameter logic [7:0] PWR_ADDR  = 8'h87,
    parameter int         PS_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             nvm_busy,
    output logic [PS_W-1:0]  ps,
    output logic             wd_en,
    output logic             kick
);
    localparam int MEM_W = F_MEM_HI - F_MEM_LO + 1;

    logic [MEM_W-1:0] mem_q;
    logic             pof_q;
    logic             wr_ctrl, wr_pwr;

    assign wr_ctrl = bus_wr && (bus_addr == CTRL_ADDR);
    assign wr_pwr  = bus_wr && (bus_addr == PWR_ADDR);

    // Stored fields; the restart bit becomes a one-cycle pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps    <= '0;
            mem_q <= '0;
            wd_en <= 1'b0;
            kick  <= 1'b0;
        end else begin
            kick <= wr_ctrl && bus_wdata[F_KICK];
            if (wr_ctrl) begin
                ps    <= bus_wdata[F_PS_LO +: PS_W];
                mem_q <= bus_wdata[F_MEM_HI:F_MEM_LO];
                wd_en <= bus_wdata[F_EN];
            end
        end
    end

    // Power-off flag: only power-on reset touches it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      pof_q <= 1'b1;
        else if (wr_pwr) pof_q <= bus_wdata[F_POF];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata[F_PS_LO +: PS_W]    = ps;
            bus_rdata[F_MEM_HI:F_MEM_LO] = mem_q;
            bus_rdata[F_KICK]            = ~nvm_busy;
            bus_rdata[F_EN]              = wd_en;
        end else if (bus_addr == PWR_ADDR) begin
            bus_rdata[F_POF] = pof_q;
        end
    end

    // R2: fields follow the written data
    a_r2_field_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ps == $past(bus_wdata[F_PS_LO +: PS_W]) && wd_en == $past(bus_wdata[F_EN])));
    // R4: a restart pulse only follows a write of 1 to bit 1
    a_r4_kick_source: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> $past(wr_ctrl && bus_wdata[F_KICK]));
    // R9: the flag holds unless its own register is written
    a_r9_pof_hold: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !wr_pwr |=> $stable(pof_q));
    // R10: no control write keeps the fields stable
    a_r10_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> ($stable(ps) && $stable(wd_en) && $stable(mem_q)));
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int BASE_TICKS = 16,
    parameter int PS_W       = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            en,
    input  logic            kick,
    input  logic [PS_W-1:0] ps,
    output logic            req
);
    localparam int MAX_TERM = BASE_TICKS << ((1 << PS_W) - 1);
    localparam int CNT_W    = $clog2(MAX_TERM);
    localparam int TERM_W   = CNT_W + 1;

    wd_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [TERM_W-1:0] term;
    logic              hit;

    assign term = TERM_W'(BASE_TICKS) << ps;
    assign hit  = en && !kick && tick && ({1'b0, cnt_q} >= term - TERM_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!en || kick) cnt_q <= '0;
        else if (hit)        cnt_q <= '0;
        else if (tick)       cnt_q <= cnt_q + CNT_W'(1);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:  state_d = !en ? WD_OFF : (hit ? WD_BITE : WD_RUN);
            WD_RUN:  state_d = !en ? WD_OFF : (hit ? WD_BITE : WD_RUN);
            WD_BITE: state_d = !en ? WD_OFF : (hit ? WD_BITE : WD_RUN);
            default: state_d = WD_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        req = (state_q == WD_BITE);
    end

    // R7: disabled means cleared and silent
    a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0 && !req));
    // R4: restart pulse clears the counter
    a_r4_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt_q == '0));
    // R5: request lasts one cycle
    a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    // R8: a request needs an accepted tick
    a_r8_req_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(tick && en));
    // R6: counting restarts from zero at expiry
    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (cnt_q == '0));
endmodule

// File: rtl/prescaled_watchdog.sv
module prescaled_watchdog #(
    parameter logic [7:0] CTRL_ADDR  = 8'h96,
    parameter logic [7:0] PWR_ADDR   = 8'h87,
    parameter int         BASE_TICKS = 16,
    parameter int         PS_W       = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_n,
    input  logic [7:0] sfr_addr,
    input  logic       sfr_wr,
    input  logic [7:0] sfr_wdata,
    output logic [7:0] sfr_rdata,
    input  logic       tick_1ms,
    input  logic       nvm_busy,
    output logic       wd_reset_req
);
    logic [PS_W-1:0] ps;
    logic            wd_en, kick;

    wdog_ctrl_reg #(
        .CTRL_ADDR (CTRL_ADDR),
        .PWR_ADDR  (PWR_ADDR),
        .PS_W      (PS_W)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_n     (por_n),
        .bus_addr  (sfr_addr),
        .bus_wr    (sfr_wr),
        .bus_wdata (sfr_wdata),
        .bus_rdata (sfr_rdata),
        .nvm_busy  (nvm_busy),
        .ps        (ps),
        .wd_en     (wd_en),
        .kick      (kick)
    );

    wdog_core #(
        .BASE_TICKS (BASE_TICKS),
        .PS_W       (PS_W)
    ) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_1ms),
        .en    (wd_en),
        .kick  (kick),
        .ps    (ps),
        .req   (wd_reset_req)
    );
endmodule

// File: tb/prescaled_watchdog_tb.sv
module prescaled_watchdog_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_n = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       tick_1ms = 1'b0;
    logic       tick_alt = 1'b0;
    logic       nvm_busy = 1'b0;
    logic       wd_reset_req;

    int n_checks = 0;
    int n_errs   = 0;

    localparam logic [7:0] CTRL = 8'h96;
    localparam logic [7:0] PWR  = 8'h87;

    prescaled_watchdog u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .por_n        (por_n),
        .sfr_addr     (sfr_addr),
        .sfr_wr       (sfr_wr),
        .sfr_wdata    (sfr_wdata),
        .sfr_rdata    (sfr_rdata),
        .tick_1ms     (tick_1ms),
        .nvm_busy     (nvm_busy),
        .wd_reset_req (wd_reset_req)
    );

    always #5 clk = ~clk;

    always @(negedge clk) tick_1ms <= tick_alt ? ~tick_1ms : 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    // counts clock edges and accepted ticks until the request is seen
    task automatic wait_req(output int edges, output int ticks);
        edges = 0; ticks = 0;
        while (1) begin
            @(posedge clk);
            if (tick_1ms) ticks++;
            @(negedge clk);
            edges++;
            if (wd_reset_req || edges >= 5000) break;
        end
    endtask

    task automatic idle(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wd_reset_req) seen++;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int e, t, s, term;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(CTRL, d);
        chk(d == 8'h02, "R1 ctrl reset", d, 8'h02);
        chk(wd_reset_req == 1'b0, "R1 no request", wd_reset_req, 0);

        // R9: power-on sets flag, other bits zero
        rd(PWR, d);
        chk(d == 8'h10, "R9 pof after power-on", d, 8'h10);

        // R2/R3: sweep all write values
        for (int v = 0; v < 256; v++) begin
            nvm_busy = v[3];
            wr(CTRL, 8'(v));
            rd(CTRL, d);
            chk(d == ((8'(v) & 8'hFD) | {6'b0, ~v[3], 1'b0}), "R2 R3 field readback", d,
                (v & 8'hFD) | ((v[3] ? 0 : 1) << 1));
        end
        nvm_busy = 1'b1;
        wr(CTRL, 8'h02);
        rd(CTRL, d);
        chk(d == 8'h00, "R3 busy reads 0, bit 1 not stored", d, 8'h00);
        nvm_busy = 1'b0;
        rd(CTRL, d);
        chk(d == 8'h02, "R3 ready reads 1", d, 8'h02);

        // R10: other address
        wr(8'h95, 8'hFF);
        rd(CTRL, d);
        chk(d == 8'h02, "R10 stray write ignored", d, 8'h02);
        rd(8'h95, d);
        chk(d == 8'h00, "R10 stray read zero", d, 0);

        // R5/R6: every period select, tick every cycle
        for (int ps = 0; ps < 8; ps++) begin
            term = 16 << ps;
            wr(CTRL, 8'h00);
            wr(CTRL, 8'((ps << 5) | 1));
            wait_req(e, t);
            chk(e == term, "R5 first period", e, term);
            @(negedge clk);
            chk(wd_reset_req == 1'b0, "R5 one-cycle request", wd_reset_req, 0);
            wait_req(e, t);
            chk(e == term - 1, "R6 repeat period", e + 1, term);
        end

        // R8: ticks on alternate cycles
        wr(CTRL, 8'h00);
        tick_alt = 1'b1;
        wr(CTRL, 8'h21);
        wait_req(e, t);
        chk(t == 32, "R8 accepted ticks", t, 32);
        chk(e > 32, "R8 edges exceed ticks", e, 33);
        tick_alt = 1'b0;

        // R4: restart postpones expiry
        wr(CTRL, 8'h00);
        wr(CTRL, 8'h01);
        idle(10, s);
        wr(CTRL, 8'h03);
        wait_req(e, t);
        chk(s == 0, "R4 no early request", s, 0);
        chk(e == 17, "R4 restart period", e, 17);

        // R7: disable silences and clears
        wr(CTRL, 8'h01);
        idle(10, s);
        wr(CTRL, 8'h00);
        idle(40, s);
        chk(s == 0, "R7 no request while disabled", s, 0);
        wr(CTRL, 8'h01);
        wait_req(e, t);
        chk(e == 16, "R7 full period after re-enable", e, 16);

        // R11: lowering the period select
        wr(CTRL, 8'h00);
        wr(CTRL, 8'h61);
        idle(40, s);
        wr(CTRL, 8'h01);
        wait_req(e, t);
        chk(e == 1, "R11 immediate expiry", e, 1);
        wr(CTRL, 8'h00);

        // R9: flag writable and kept over ordinary reset
        wr(PWR, 8'h00);
        rd(PWR, d);
        chk(d == 8'h00, "R9 pof cleared", d, 0);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        rd(PWR, d);
        chk(d == 8'h00, "R9 clear kept over reset", d, 0);
        wr(PWR, 8'hFF);
        rd(PWR, d);
        chk(d == 8'h10, "R9 pof set, other bits zero", d, 8'h10);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        rd(PWR, d);
        chk(d == 8'h10, "R9 set kept over reset", d, 8'h10);
        rd(CTRL, d);
        chk(d == 8'h02, "R1 ctrl reset again", d, 8'h02);

        finish_run();
    end
endmodule